// File: doc/BRIEF.md
# Lane-Parallel Element-Wise Matrix Execution Controller

This block holds the lane control registers of a small matrix unit and runs element-wise integer operations over a register file split across four lanes. A configuration instruction sets a strip count, a strip width and a third dimension value. Each later element-wise instruction names a destination and two source registers. The block then processes the active elements one row at a time, with one element per lane in each cycle. Element `e` of any register lives in lane `e mod 4`, at row `e div 4` of that lane's slice.

A single-element write port and a combinational read port give the load and store datapath access to the register file. Instructions arrive on a valid/ready pair. While an operation runs, `in_ready` is low and the instruction on the input is held.

The sequencer has two states. In IDLE it accepts instructions. An accepted element-wise instruction moves it to RUN (transition START). In RUN it writes one row per cycle and stays in RUN (transition STEP) until the last active row is written, then returns to IDLE (transition FINISH). A configuration instruction is taken in IDLE and leaves the state unchanged (transition CONFIG).

Top module: `lane_mx_ctrl`

## Requirements
- R1: An instruction with class bits [31:26] = 010010 and opcode bits [5:0] = 000000 is a configuration instruction. On acceptance it loads the strip count from bits [25:16], the strip width from bits [15:11] and the dimension from bits [10:6]. The new values appear on `cfg_strips`, `cfg_width` and `cfg_dim` after that clock edge, and `busy` stays low.
- R2: A strip count field of 0 is stored as 1024, and a strip width field of 0 is stored as 32. Other field values are stored unchanged. The dimension field is always stored unchanged.
- R3: After reset, `in_ready`=1, `busy`=0, `cfg_strips`=1, `cfg_width`=1 and `cfg_dim`=0.
- R4: An instruction with class 010010 and opcode 000001 (add), 000010 (subtract) or 000011 (multiply) is element-wise. Its destination register is bits [25:23], source A is bits [22:20] and source B is bits [19:17]. Each active element becomes A op B, truncated to the low 32 bits. Subtract computes A minus B.
- R5: The active element count is min(strips × width, 32). Elements with an index at or above the count keep their values.
- R6: `busy` rises in the cycle after an element-wise instruction is accepted. It stays high for exactly ceil(count/4) cycles, one row per cycle.
- R7: `in_ready` is low exactly while `busy` is high. An instruction held on the input is accepted once `in_ready` returns, and it sees the results of the previous operation.
- R8: When idle, `wr_en` writes `wr_data` to element `wr_idx` of register `wr_reg`. The element sits in lane `wr_idx` mod 4, row `wr_idx` div 4. `rd_data` shows element `rd_idx` of register `rd_reg` without delay. A write presented while `busy` is high is ignored.
- R9: A write made in the same cycle that an element-wise instruction is accepted is performed, and the operation reads the newly written value.
- R10: An instruction with any other class, or with class 010010 and any opcode above 000011, is accepted and ignored. It changes no control register and no element, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when high |
| in_instr | input | 32 | Instruction word |
| wr_en | input | 1 | Element write strobe |
| wr_reg | input | 3 | Register to write |
| wr_idx | input | 5 | Element index to write |
| wr_data | input | 32 | Element write value |
| rd_reg | input | 3 | Register to read |
| rd_idx | input | 5 | Element index to read |
| rd_data | output | 32 | Element read value |
| busy | output | 1 | Element-wise operation in progress |
| cfg_strips | output | 11 | Stored strip count (1 to 1024) |
| cfg_width | output | 6 | Stored strip width (1 to 32) |
| cfg_dim | output | 5 | Stored dimension value |

## Verification
Two functions can fall in the same cycle: an external element write and the acceptance of an element-wise instruction. A second collision is an external write attempted while the sequencer is writing rows. The bench provokes the first case by raising `wr_en` and `in_valid` in the same cycle. It passes the case if the result uses the freshly written source value. The bench provokes the second case by writing into an untouched register in the middle of a run. It passes the case if that element keeps its old value once the run ends.

// File: rtl/lmx_pkg.sv
`timescale 1ns/1ps
package lmx_pkg;
    localparam logic [5:0] CLS_MX   = 6'b010010;
    localparam int         REG_FW   = 3;
    localparam int         NREG     = 2 ** REG_FW;
    localparam int         STRIP_FW = 10;
    localparam int         WIDTH_FW = 5;
    localparam int         DIM_FW   = 5;
    localparam int         SW       = STRIP_FW + 1;
    localparam int         WW       = WIDTH_FW + 1;

    typedef enum logic [5:0] {
        OP_CFG = 6'd0,
        OP_ADD = 6'd1,
        OP_SUB = 6'd2,
        OP_MUL = 6'd3
    } opc_e;
endpackage

// File: rtl/lmx_cfg_regs.sv
`timescale 1ns/1ps
module lmx_cfg_regs
    import lmx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [STRIP_FW-1:0] fld_strips,
    input  logic [WIDTH_FW-1:0] fld_width,
    input  logic [DIM_FW-1:0]   fld_dim,
    output logic [SW-1:0]       strips,
    output logic [WW-1:0]       width,
    output logic [DIM_FW-1:0]   dim
);
    logic [SW-1:0] strips_dec;
    logic [WW-1:0] width_dec;

    // zero field selects the maximum: the extra top bit is set exactly then
    assign strips_dec = {(fld_strips == '0), fld_strips};
    assign width_dec  = {(fld_width == '0), fld_width};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strips <= SW'(1);
            width  <= WW'(1);
            dim    <= '0;
        end else if (load) begin
            strips <= strips_dec;
            width  <= width_dec;
            dim    <= fld_dim;
        end
    end
endmodule

// File: rtl/lmx_lane.sv
`timescale 1ns/1ps
module lmx_lane
    import lmx_pkg::*;
#(
    parameter  int ROWS = 8,
    parameter  int DW   = 32,
    localparam int RW   = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              ext_we,
    input  logic [REG_FW-1:0] ext_reg,
    input  logic [RW-1:0]     ext_row,
    input  logic [DW-1:0]     ext_data,
    input  logic              exe_we,
    input  opc_e              exe_op,
    input  logic [REG_FW-1:0] exe_dst,
    input  logic [REG_FW-1:0] exe_sa,
    input  logic [REG_FW-1:0] exe_sb,
    input  logic [RW-1:0]     exe_row,
    input  logic [REG_FW-1:0] rd_reg,
    input  logic [RW-1:0]     rd_row,
    output logic [DW-1:0]     rd_data
);
    logic [DW-1:0] slice [NREG][ROWS];
    logic [DW-1:0] opa, opb, res;

    assign opa     = slice[exe_sa][exe_row];
    assign opb     = slice[exe_sb][exe_row];
    assign rd_data = slice[rd_reg][rd_row];

    always_comb begin
        unique case (exe_op)
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_MUL:  res = opa * opb;
            default: res = opa;
        endcase
    end

    // sequencer and external writes are mutually exclusive by busy gating
    always_ff @(posedge clk) begin
        if (exe_we)
            slice[exe_dst][exe_row] <= res;
        else if (ext_we)
            slice[ext_reg][ext_row] <= ext_data;
    end
endmodule

// File: rtl/lmx_seq.sv
`timescale 1ns/1ps
module lmx_seq
    import lmx_pkg::*;
#(
    parameter  int LANES = 4,
    parameter  int ROWS  = 8,
    localparam int LW    = $clog2(LANES),
    localparam int RW    = $clog2(ROWS),
    localparam int ELEMS = LANES * ROWS,
    localparam int EW    = $clog2(ELEMS),
    localparam int CW    = EW + 1,
    localparam int PW    = SW + WW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [5:0]        in_cls,
    input  logic [5:0]        in_opc,
    input  logic [3*REG_FW-1:0] in_regs,
    input  logic [SW-1:0]     strips,
    input  logic [WW-1:0]     width,
    output logic              in_ready,
    output logic              busy,
    output logic              cfg_load,
    output opc_e              exe_op,
    output logic [REG_FW-1:0] exe_dst,
    output logic [REG_FW-1:0] exe_sa,
    output logic [REG_FW-1:0] exe_sb,
    output logic [RW-1:0]     exe_row,
    output logic [LANES-1:0]  exe_we
);
    typedef enum logic {S_IDLE, S_RUN} st_e;

    st_e           st_q, st_d;
    logic          is_mx, is_cfg, is_elem, take;
    logic [PW-1:0] prod;
    logic [CW-1:0] cnt_d, cnt_q;
    logic [EW-1:0] last_idx;
    logic [RW-1:0] last_d, last_q, row_q;
    opc_e          op_q;
    logic [REG_FW-1:0] dst_q, sa_q, sb_q;

    assign is_mx   = (in_cls == CLS_MX);
    assign is_cfg  = is_mx && (in_opc == OP_CFG);
    assign is_elem = is_mx && ((in_opc == OP_ADD) || (in_opc == OP_SUB) || (in_opc == OP_MUL));
    assign take    = in_valid && (st_q == S_IDLE) && is_elem;

    assign prod     = PW'(strips) * PW'(width);
    assign cnt_d    = (prod > PW'(ELEMS)) ? CW'(ELEMS) : prod[CW-1:0];
    assign last_idx = EW'(cnt_d - CW'(1));
    assign last_d   = last_idx[EW-1:LW];

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (take) st_d = S_RUN;
            S_RUN:  if (row_q == last_q) st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            last_q <= '0;
            cnt_q  <= '0;
            op_q   <= OP_ADD;
            dst_q  <= '0;
            sa_q   <= '0;
            sb_q   <= '0;
        end else if (take) begin
            row_q  <= '0;
            last_q <= last_d;
            cnt_q  <= cnt_d;
            op_q   <= opc_e'(in_opc);
            dst_q  <= in_regs[3*REG_FW-1:2*REG_FW];
            sa_q   <= in_regs[2*REG_FW-1:REG_FW];
            sb_q   <= in_regs[REG_FW-1:0];
        end else if (st_q == S_RUN) begin
            row_q  <= row_q + RW'(1);
        end
    end

    always_comb begin
        in_ready = (st_q == S_IDLE);
        busy     = (st_q == S_RUN);
        cfg_load = in_valid && (st_q == S_IDLE) && is_cfg;
        exe_op   = op_q;
        exe_dst  = dst_q;
        exe_sa   = sa_q;
        exe_sb   = sb_q;
        exe_row  = row_q;
        for (int l = 0; l < LANES; l++)
            exe_we[l] = (st_q == S_RUN) && ({1'b0, row_q, LW'(l)} < cnt_q);
    end
endmodule

// File: rtl/lane_mx_ctrl.sv
`timescale 1ns/1ps
module lane_mx_ctrl
    import lmx_pkg::*;
#(
    parameter  int LANES = 4,
    parameter  int ROWS  = 8,
    parameter  int DW    = 32,
    localparam int LW    = $clog2(LANES),
    localparam int RW    = $clog2(ROWS),
    localparam int EW    = $clog2(LANES * ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_instr,
    input  logic              wr_en,
    input  logic [REG_FW-1:0] wr_reg,
    input  logic [EW-1:0]     wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic [REG_FW-1:0] rd_reg,
    input  logic [EW-1:0]     rd_idx,
    output logic [DW-1:0]     rd_data,
    output logic              busy,
    output logic [SW-1:0]     cfg_strips,
    output logic [WW-1:0]     cfg_width,
    output logic [DIM_FW-1:0] cfg_dim
);
    logic              cfg_load;
    opc_e              exe_op;
    logic [REG_FW-1:0] exe_dst, exe_sa, exe_sb;
    logic [RW-1:0]     exe_row;
    logic [LANES-1:0]  exe_we;
    logic [DW-1:0]     lane_rd [LANES];

    lmx_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .fld_strips (in_instr[25:16]),
        .fld_width  (in_instr[15:11]),
        .fld_dim    (in_instr[10:6]),
        .strips     (cfg_strips),
        .width      (cfg_width),
        .dim        (cfg_dim)
    );

    lmx_seq #(.LANES(LANES), .ROWS(ROWS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_cls   (in_instr[31:26]),
        .in_opc   (in_instr[5:0]),
        .in_regs  (in_instr[25:17]),
        .strips   (cfg_strips),
        .width    (cfg_width),
        .in_ready (in_ready),
        .busy     (busy),
        .cfg_load (cfg_load),
        .exe_op   (exe_op),
        .exe_dst  (exe_dst),
        .exe_sa   (exe_sa),
        .exe_sb   (exe_sb),
        .exe_row  (exe_row),
        .exe_we   (exe_we)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lmx_lane #(.ROWS(ROWS), .DW(DW)) u_lane (
            .clk      (clk),
            .ext_we   (wr_en && !busy && (wr_idx[LW-1:0] == LW'(l))),
            .ext_reg  (wr_reg),
            .ext_row  (wr_idx[EW-1:LW]),
            .ext_data (wr_data),
            .exe_we   (exe_we[l]),
            .exe_op   (exe_op),
            .exe_dst  (exe_dst),
            .exe_sa   (exe_sa),
            .exe_sb   (exe_sb),
            .exe_row  (exe_row),
            .rd_reg   (rd_reg),
            .rd_row   (rd_idx[EW-1:LW]),
            .rd_data  (lane_rd[l])
        );
    end

    assign rd_data = lane_rd[rd_idx[LW-1:0]];
endmodule

// File: rtl/lmx_chk.sv
`timescale 1ns/1ps
module lmx_chk
    import lmx_pkg::*;
#(
    parameter int ROWS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [5:0]        in_cls,
    input logic [5:0]        in_opc,
    input logic              busy,
    input logic [SW-1:0]     cfg_strips,
    input logic [WW-1:0]     cfg_width,
    input logic [DIM_FW-1:0] cfg_dim
);
    logic acc, acc_cfg, acc_elem;
    int unsigned run_len;

    assign acc      = in_valid && in_ready;
    assign acc_cfg  = acc && (in_cls == CLS_MX) && (in_opc == 6'd0);
    assign acc_elem = acc && (in_cls == CLS_MX) && (in_opc >= 6'd1) && (in_opc <= 6'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R7: ready and busy are complementary
    a_r7_ready_vs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == !busy);

    // R6: accepted element-wise instruction starts a run
    a_r6_start_run: assert property (@(posedge clk) disable iff (!rst_n)
        acc_elem |=> busy);

    // R6: a run never exceeds the row count
    a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < ROWS));

    // R1: control registers change only on a configuration instruction
    a_r1_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_cfg |=> ($stable(cfg_strips) && $stable(cfg_width) && $stable(cfg_dim)));

    // R10: an unrecognised instruction leaves the block idle
    a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !acc_cfg && !acc_elem) |=> !busy);

    // R2: stored values stay in their legal ranges
    a_r2_cfg_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_strips >= SW'(1)) && (cfg_strips <= SW'(1024)) &&
        (cfg_width >= WW'(1)) && (cfg_width <= WW'(32)));
endmodule

bind lane_mx_ctrl lmx_chk #(.ROWS(ROWS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_cls     (in_instr[31:26]),
    .in_opc     (in_instr[5:0]),
    .busy       (busy),
    .cfg_strips (cfg_strips),
    .cfg_width  (cfg_width),
    .cfg_dim    (cfg_dim)
);

// File: tb/lane_mx_ctrl_bench.sv
`timescale 1ns/1ps
module lane_mx_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_reg = '0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_reg = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        busy;
    logic [10:0] cfg_strips;
    logic [5:0]  cfg_width;
    logic [4:0]  cfg_dim;

    int checks = 0;
    int errors = 0;
    logic [31:0] m [8][32];

    always #2.5 clk = ~clk;

    lane_mx_ctrl u_lane_mx_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
        .busy(busy), .cfg_strips(cfg_strips), .cfg_width(cfg_width), .cfg_dim(cfg_dim)
    );

    // table entry: [31:22] strip field, [21:17] width field, [16:15] op,
    // [14:12] dst, [11:9] srcA, [8:6] srcB
    localparam int NT = 6;
    localparam logic [31:0] TBL [NT] = '{
        {10'd8, 5'd4, 2'd1, 3'd2, 3'd0, 3'd1, 6'd0},
        {10'd2, 5'd3, 2'd2, 3'd3, 3'd4, 3'd5, 6'd0},
        {10'd0, 5'd1, 2'd3, 3'd6, 3'd1, 3'd6, 6'd0},
        {10'd1, 5'd0, 2'd1, 3'd0, 3'd0, 3'd0, 6'd0},
        {10'd5, 5'd1, 2'd3, 3'd5, 3'd5, 3'd5, 6'd0},
        {10'd1, 5'd1, 2'd2, 3'd1, 3'd7, 3'd2, 6'd0}
    };

    function automatic logic [31:0] ctrl_w(input logic [9:0] s, input logic [4:0] w, input logic [4:0] d);
        return {6'b010010, s, w, d, 6'b000000};
    endfunction

    function automatic logic [31:0] elem_w(input logic [5:0] op, input logic [2:0] d,
                                           input logic [2:0] a, input logic [2:0] b);
        return {6'b010010, d, a, b, 11'd0, op};
    endfunction

    function automatic logic [31:0] alu(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            6'd1:    return a + b;
            6'd2:    return a - b;
            default: return a * b;
        endcase
    endfunction

    function automatic int eff_count(input int s, input int w);
        int t;
        t = (s == 0 ? 1024 : s) * (w == 0 ? 32 : w);
        return (t > 32) ? 32 : t;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_op(input logic [5:0] op, input int d, input int a, input int b, input int cnt);
        for (int e = 0; e < cnt; e++) m[d][e] = alu(op, m[a][e], m[b][e]);
    endtask

    task automatic issue(input logic [31:0] ins);
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = ins;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic write_el(input int r, input int e, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_reg = 3'(r); wr_idx = 5'(e); wr_data = v;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle;
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic check_reg(input int r, input string req);
        for (int e = 0; e < 32; e++) begin
            rd_reg = 3'(r); rd_idx = 5'(e);
            #0.2;
            check(rd_data === m[r][e], req, rd_data, m[r][e]);
        end
    endtask

    task automatic check_cfg(input int s, input int w, input int d, input string req);
        check(cfg_strips === 11'(s), req, 32'(cfg_strips), s);
        check(cfg_width === 6'(w), req, 32'(cfg_width), w);
        check(cfg_dim === 5'(d), req, 32'(cfg_dim), d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int nb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        check(in_ready === 1'b1, "R3", 32'(in_ready), 1);
        check(busy === 1'b0, "R3", 32'(busy), 0);
        check_cfg(1, 1, 0, "R3");

        // R8 fill and read back
        for (int r = 0; r < 8; r++)
            for (int e = 0; e < 32; e++) begin
                m[r][e] = 32'h9E3779B9 * 32'(r * 32 + e + 1) + 32'(r);
                write_el(r, e, m[r][e]);
            end
        @(negedge clk);
        for (int r = 0; r < 8; r++) check_reg(r, "R8");

        // R1 decode
        issue(ctrl_w(10'd6, 5'd3, 5'd17));
        @(negedge clk);
        check_cfg(6, 3, 17, "R1");
        check(busy === 1'b0, "R1", 32'(busy), 0);

        // R2 zero encoding
        issue(ctrl_w(10'd0, 5'd0, 5'd0));
        @(negedge clk);
        check_cfg(1024, 32, 0, "R2");

        // R10 foreign class and unused opcode
        issue({6'b010011, 10'd5, 5'd5, 5'd5, 6'd0});
        @(negedge clk);
        check(busy === 1'b0, "R10", 32'(busy), 0);
        check_cfg(1024, 32, 0, "R10");
        issue(elem_w(6'd7, 3'd4, 3'd0, 3'd1));
        @(negedge clk);
        check(busy === 1'b0, "R10", 32'(busy), 0);
        check_reg(4, "R10");

        // R4 R5 R6 table
        for (int t = 0; t < NT; t++) begin
            logic [31:0] v;
            int cnt;
            v = TBL[t];
            cnt = eff_count(int'(v[31:22]), int'(v[21:17]));
            issue(ctrl_w(v[31:22], v[21:17], 5'd0));
            issue(elem_w(6'(v[16:15]), v[14:12], v[11:9], v[8:6]));
            nb = 0;
            @(negedge clk);
            while (busy) begin nb++; @(negedge clk); end
            check(nb == (cnt + 3) / 4, "R6", nb, (cnt + 3) / 4);
            model_op(6'(v[16:15]), int'(v[14:12]), int'(v[11:9]), int'(v[8:6]), cnt);
            check_reg(int'(v[14:12]), "R4 R5");
        end

        // R7 stall and ordering
        issue(ctrl_w(10'd8, 5'd4, 5'd0));
        issue(elem_w(6'd1, 3'd2, 3'd0, 3'd1));
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = elem_w(6'd2, 3'd3, 3'd2, 3'd0);
        check(in_ready === 1'b0, "R7", 32'(in_ready), 0);
        check(busy === 1'b1, "R7", 32'(busy), 1);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        model_op(6'd1, 2, 0, 1, 32);
        model_op(6'd2, 3, 2, 0, 32);
        wait_idle();
        check_reg(2, "R7");
        check_reg(3, "R7");

        // R8 write ignored while busy
        issue(elem_w(6'd1, 3'd2, 3'd0, 3'd1));
        @(negedge clk);
        wr_en = 1'b1; wr_reg = 3'd7; wr_idx = 5'd5; wr_data = 32'hDEADBEEF;
        check(busy === 1'b1, "R8", 32'(busy), 1);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_op(6'd1, 2, 0, 1, 32);
        wait_idle();
        check_reg(7, "R8");
        check_reg(2, "R8");

        // R9 write in acceptance cycle
        issue(ctrl_w(10'd2, 5'd2, 5'd0));
        @(negedge clk);
        in_valid = 1'b1; in_instr = elem_w(6'd3, 3'd4, 3'd5, 3'd6);
        wr_en = 1'b1; wr_reg = 3'd5; wr_idx = 5'd0; wr_data = 32'd3;
        @(posedge clk);
        #1;
        in_valid = 1'b0; wr_en = 1'b0;
        m[5][0] = 32'd3;
        model_op(6'd3, 4, 5, 6, 4);
        wait_idle();
        check_reg(4, "R9");
        check_reg(5, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule